// File: doc/BRIEF.md
# Host-Side Serial Port Register Mirror

This block makes a local microprocessor appear to a host bus as a 16550-style serial port. Nothing is shifted onto a wire. The host sees a small register file through a 3-bit address, an 8-bit data path, an active-low chip select and active-low read and write strobes. The local MPU sits on the other side. It places received bytes into the host's receive buffer and collects the bytes that the host writes into the transmit holding register.

The host strobes are asynchronous to the block clock. They pass through a flop synchronizer, and an access takes effect on a single clock edge after the synchronized strobe is detected. Data-ready, overrun and transmit-holding-empty flags move as bytes pass between the two sides. A host interrupt output follows those flags, gated by an enable register, with a fixed latency in system clocks. A registered driver-disable output tells an external bus transceiver when the host is reading.

Top module: `uart_host_mirror`

## Requirements
- R1: After reset, host_irq is 0, host_drv_dis_n is 1, the line status register reads 0x60, the identification register reads 0x01 and the enable register reads 0x00.
- R2: The host register map is: address 0 is the receive buffer on reads and the transmit holding register on writes, 1 is the interrupt enable register, 2 is the interrupt identification register (read only), and 5 is the line status register (read only). Any other address reads 0x00 and ignores writes. A strobe that arrives while host_cs_n is high has no effect.
- R3: A host access takes effect on the third rising clock edge at which chip select and the strobe are both seen low. Writing the enable register while transmit-holding-empty is set raises host_irq 5 edges after the strobe is asserted.
- R4: An MPU write at MPU address 0 loads the receive buffer and sets data-ready (line status bit 0). With enable bit 0 set, host_irq rises two clocks after the edge that samples the write.
- R5: A host read of the receive buffer clears data-ready. The receive interrupt drops two clocks after the access takes effect.
- R6: A host write to address 0 captures the byte and clears transmit-holding-empty (line status bits 5 and 6). The transmit interrupt drops three clocks after the access takes effect.
- R7: An MPU read at MPU address 0 returns the captured byte and sets transmit-holding-empty. With enable bit 1 set, host_irq rises two clocks after the sampling edge.
- R8: host_drv_dis_n goes low one clock after chip select and the read strobe are both low, and returns high one clock after either one is released.
- R9: An MPU receive write while data-ready is still set sets overrun (line status bit 1), unless a host receive-buffer read takes effect on the same edge. A host read of the line status register clears overrun. With enable bit 2 set, overrun is an interrupt source.
- R10: The identification register reports the highest-priority enabled pending source: 0x06 for overrun, 0x04 for data-ready, 0x02 for transmit-holding-empty, and 0x01 when none is pending. host_irq is the OR of the enabled sources, delayed by two clocks. Only enable bits 2:0 are stored.
- R11: MPU reads are registered: MPU address 0 returns the transmit byte, 1 returns line status, 2 returns the enable register and 3 returns 0x00. mpu_rdata holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_drv_dis_n | output | 1 | Low while the host reads, for transceiver direction |
| host_irq | output | 1 | Host interrupt request, active high |
| mpu_addr | input | 2 | Local MPU register select |
| mpu_wdata | input | 8 | Local MPU write data |
| mpu_rdata | output | 8 | Local MPU read data, registered |
| mpu_wr | input | 1 | Local MPU write enable, one clock |
| mpu_rd | input | 1 | Local MPU read enable, one clock |

## Verification
The assertions check on every cycle that an MPU receive write or transmit read with the matching enable bit set produces host_irq two clocks later. They also check that host_irq stays low once the enable register has been zero for two cycles, that driver-disable falls only after a sampled host read, and that the synchronized strobe never yields two back-to-back access pulses. The bench's scenarios show the rest. These are the exact edge counts from host strobe to interrupt change, the three-clock transmit clear against the two-clock receive clear, the overrun set and clear sequence, the identification priority order, and writes or strobes without chip select leaving the registers untouched.

// File: rtl/hmx_pkg.sv
package hmx_pkg;
  // Host register addresses (host software decodes these positions)
  localparam logic [2:0] HA_DATA = 3'd0;
  localparam logic [2:0] HA_IEN  = 3'd1;
  localparam logic [2:0] HA_IID  = 3'd2;
  localparam logic [2:0] HA_LST  = 3'd5;

  // Local MPU register selects
  localparam logic [1:0] MA_DATA = 2'd0;
  localparam logic [1:0] MA_LST  = 2'd1;
  localparam logic [1:0] MA_IEN  = 2'd2;

  // Line status bit positions
  localparam int LS_DR   = 0;
  localparam int LS_OE   = 1;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;

  // Interrupt enable bit positions
  localparam int IE_RX  = 0;
  localparam int IE_TX  = 1;
  localparam int IE_LS  = 2;
  localparam int IE_CNT = 3;

  // Identification codes
  localparam int ID_LS   = 6;
  localparam int ID_RX   = 4;
  localparam int ID_TX   = 2;
  localparam int ID_NONE = 1;
endpackage

// File: rtl/hmx_strobe_sync.sv
module hmx_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic go
);
  logic [STAGES-1:0] chain;
  logic              seen_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= chain[STAGES-1];
  end

  assign go = chain[STAGES-1] & ~seen_q;

  // R3: one access pulse per synchronized strobe assertion
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);
endmodule

// File: rtl/hmx_pipe.sv
module hmx_pipe #(
  parameter int DEPTH = 2,
  parameter int W     = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_st
    if (g == 0) begin : g_in
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else     stage[g] <= d;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= '0;
        else     stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/hmx_regfile.sv
module hmx_regfile
  import hmx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int HADDR_W = 3,
  parameter int MADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_rd_go,
  input  logic               host_wr_go,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               mpu_wr,
  input  logic               mpu_rd,
  input  logic [MADDR_W-1:0] mpu_addr,
  input  logic [DATA_W-1:0]  mpu_wdata,
  output logic [DATA_W-1:0]  mpu_rdata,
  input  logic               thr_clr,
  output logic               thr_wr,
  output logic               pend_any,
  output logic [DATA_W-1:0]  ier_o
);
  localparam logic [DATA_W-1:0] IER_MASK = DATA_W'((1 << IE_CNT) - 1);

  logic              dr_q, oe_q, thre_q;
  logic [DATA_W-1:0] ier_q, rbr_q, thr_q;
  logic [DATA_W-1:0] lsr, iid;
  logic              rd_rbr, rd_lsr, wr_ier, m_put, m_take;
  logic              ls_p, rx_p, tx_p;

  assign rd_rbr = host_rd_go && (host_addr == HADDR_W'(HA_DATA));
  assign rd_lsr = host_rd_go && (host_addr == HADDR_W'(HA_LST));
  assign thr_wr = host_wr_go && (host_addr == HADDR_W'(HA_DATA));
  assign wr_ier = host_wr_go && (host_addr == HADDR_W'(HA_IEN));
  assign m_put  = mpu_wr && (mpu_addr == MADDR_W'(MA_DATA));
  assign m_take = mpu_rd && (mpu_addr == MADDR_W'(MA_DATA));

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      thre_q <= 1'b1;
      ier_q  <= '0;
      rbr_q  <= '0;
      thr_q  <= '0;
    end else begin
      if (m_put) begin
        rbr_q <= mpu_wdata;
        dr_q  <= 1'b1;
      end else if (rd_rbr) begin
        dr_q  <= 1'b0;
      end
      if (m_put && dr_q && !rd_rbr) oe_q <= 1'b1;
      else if (rd_lsr)              oe_q <= 1'b0;
      if (thr_wr) thr_q <= host_wdata;
      if (m_take)       thre_q <= 1'b1;
      else if (thr_clr) thre_q <= 1'b0;
      if (wr_ier) ier_q <= host_wdata & IER_MASK;
    end
  end

  always_comb begin
    lsr          = '0;
    lsr[LS_DR]   = dr_q;
    lsr[LS_OE]   = oe_q;
    lsr[LS_THRE] = thre_q;
    lsr[LS_TEMT] = thre_q;
  end

  assign ls_p     = oe_q   & ier_q[IE_LS];
  assign rx_p     = dr_q   & ier_q[IE_RX];
  assign tx_p     = thre_q & ier_q[IE_TX];
  assign pend_any = ls_p | rx_p | tx_p;
  assign ier_o    = ier_q;

  always_comb begin
    if (ls_p)      iid = DATA_W'(ID_LS);
    else if (rx_p) iid = DATA_W'(ID_RX);
    else if (tx_p) iid = DATA_W'(ID_TX);
    else           iid = DATA_W'(ID_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      case (host_addr)
        HADDR_W'(HA_DATA): host_rdata <= rbr_q;
        HADDR_W'(HA_IEN):  host_rdata <= ier_q;
        HADDR_W'(HA_IID):  host_rdata <= iid;
        HADDR_W'(HA_LST):  host_rdata <= lsr;
        default:           host_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mpu_rdata <= '0;
    end else if (mpu_rd) begin
      case (mpu_addr)
        MADDR_W'(MA_DATA): mpu_rdata <= thr_q;
        MADDR_W'(MA_LST):  mpu_rdata <= lsr;
        MADDR_W'(MA_IEN):  mpu_rdata <= ier_q;
        default:           mpu_rdata <= '0;
      endcase
    end
  end

  // R9: overrun can only appear while a received byte is still held
  a_r9_oe_needs_dr: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> dr_q);
endmodule

// File: rtl/uart_host_mirror.sv
module uart_host_mirror
  import hmx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HADDR_W     = 3,
  parameter int MADDR_W     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_LAT     = 2,
  parameter int THR_CLR_LAT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic               host_cs_n,
  input  logic               host_rd_n,
  input  logic               host_wr_n,
  output logic               host_drv_dis_n,
  output logic               host_irq,
  input  logic [MADDR_W-1:0] mpu_addr,
  input  logic [DATA_W-1:0]  mpu_wdata,
  output logic [DATA_W-1:0]  mpu_rdata,
  input  logic               mpu_wr,
  input  logic               mpu_rd
);
  logic              rd_raw, wr_raw, rd_go, wr_go;
  logic              thr_wr, thr_clr, pend_any;
  logic [DATA_W-1:0] ier_w;

  assign rd_raw = ~host_cs_n & ~host_rd_n;
  assign wr_raw = ~host_cs_n & ~host_wr_n;

  hmx_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst(rst), .async_in(rd_raw), .go(rd_go));

  hmx_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .async_in(wr_raw), .go(wr_go));

  hmx_regfile #(.DATA_W(DATA_W), .HADDR_W(HADDR_W), .MADDR_W(MADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .host_rd_go(rd_go), .host_wr_go(wr_go),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mpu_wr(mpu_wr), .mpu_rd(mpu_rd), .mpu_addr(mpu_addr),
    .mpu_wdata(mpu_wdata), .mpu_rdata(mpu_rdata),
    .thr_clr(thr_clr), .thr_wr(thr_wr), .pend_any(pend_any), .ier_o(ier_w));

  hmx_pipe #(.DEPTH(THR_CLR_LAT), .W(1)) u_thr_dly (
    .clk(clk), .rst(rst), .d(thr_wr), .q(thr_clr));

  hmx_pipe #(.DEPTH(IRQ_LAT), .W(1)) u_irq_dly (
    .clk(clk), .rst(rst), .d(pend_any), .q(host_irq));

  always_ff @(posedge clk) begin
    if (rst) host_drv_dis_n <= 1'b1;
    else     host_drv_dis_n <= ~rd_raw;
  end

  // R8: driver disable only falls after a sampled host read
  a_r8_drv_after_read: assert property (@(posedge clk) disable iff (rst)
    $fell(host_drv_dis_n) |-> $past(!host_cs_n && !host_rd_n));

  if (IRQ_LAT == 2) begin : g_lat_chk
    // R4: MPU receive write with receive enable raises the interrupt two clocks on
    a_r4_rx_irq_rise: assert property (@(posedge clk) disable iff (rst)
      $past(mpu_wr && mpu_addr == MADDR_W'(MA_DATA)) && ier_w[IE_RX] |-> ##2 host_irq);
    // R7: MPU transmit read with transmit enable raises the interrupt two clocks on
    a_r7_tx_irq_rise: assert property (@(posedge clk) disable iff (rst)
      $past(mpu_rd && mpu_addr == MADDR_W'(MA_DATA)) && ier_w[IE_TX] |-> ##2 host_irq);
    // R10: with every source disabled for two cycles the interrupt stays low
    a_r10_ier_off: assert property (@(posedge clk) disable iff (rst)
      (ier_w == '0) && $past(ier_w == '0) |=> !host_irq);
  end
endmodule

// File: tb/sim_uart_host_mirror.sv
module sim_uart_host_mirror;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic       host_drv_dis_n, host_irq;
  logic [1:0] mpu_addr = 2'd0;
  logic [7:0] mpu_wdata = 8'd0;
  logic [7:0] mpu_rdata;
  logic       mpu_wr = 1'b0, mpu_rd = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_host_mirror u0 (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_wr_n(host_wr_n), .host_drv_dis_n(host_drv_dis_n), .host_irq(host_irq),
    .mpu_addr(mpu_addr), .mpu_wdata(mpu_wdata), .mpu_rdata(mpu_rdata),
    .mpu_wr(mpu_wr), .mpu_rd(mpu_rd));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        m_dr, m_oe, m_thre, m_clr_next;
  int        m_ier, m_rbr, m_thr;
  int        rd_age, wr_age;
  bit        p1, p2, e_irq, e_drv;
  int        e_dout, e_mrd;

  function automatic bit m_pend();
    return (m_oe && m_ier[2]) || (m_dr && m_ier[0]) || (m_thre && m_ier[1]);
  endfunction
  function automatic int m_lsr();
    return (m_dr ? 1 : 0) + (m_oe ? 2 : 0) + (m_thre ? 32'h60 : 0);
  endfunction
  function automatic int m_iid();
    if (m_oe && m_ier[2]) return 6;
    if (m_dr && m_ier[0]) return 4;
    if (m_thre && m_ier[1]) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dr = 0; m_oe = 0; m_thre = 1; m_clr_next = 0;
      m_ier = 0; m_rbr = 0; m_thr = 0; rd_age = 0; wr_age = 0;
      p1 = 0; p2 = 0; e_irq = 0; e_drv = 1; e_dout = 0; e_mrd = 0;
    end else begin
      bit rd_now, wr_now, clr_now, put, take;
      case (host_addr)
        3'd0: e_dout = m_rbr;
        3'd1: e_dout = m_ier;
        3'd2: e_dout = m_iid();
        3'd5: e_dout = m_lsr();
        default: e_dout = 0;
      endcase
      if (mpu_rd) begin
        case (mpu_addr)
          2'd0: e_mrd = m_thr;
          2'd1: e_mrd = m_lsr();
          2'd2: e_mrd = m_ier;
          default: e_mrd = 0;
        endcase
      end
      e_drv  = !(!host_cs_n && !host_rd_n);
      rd_age = (!host_cs_n && !host_rd_n) ? rd_age + 1 : 0;
      wr_age = (!host_cs_n && !host_wr_n) ? wr_age + 1 : 0;
      rd_now = (rd_age == 3);
      wr_now = (wr_age == 3);
      put    = mpu_wr && mpu_addr == 2'd0;
      take   = mpu_rd && mpu_addr == 2'd0;
      clr_now    = m_clr_next;
      m_clr_next = wr_now && host_addr == 3'd0;
      if (put && m_dr && !(rd_now && host_addr == 3'd0)) m_oe = 1;
      else if (rd_now && host_addr == 3'd5) m_oe = 0;
      if (put) begin m_dr = 1; m_rbr = mpu_wdata; end
      else if (rd_now && host_addr == 3'd0) m_dr = 0;
      if (wr_now && host_addr == 3'd0) m_thr = host_wdata;
      if (wr_now && host_addr == 3'd1) m_ier = host_wdata & 8'h07;
      if (take) m_thre = 1;
      else if (clr_now) m_thre = 0;
      e_irq = p2; p2 = p1; p1 = m_pend();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(host_irq == e_irq, "R10 irq", host_irq, e_irq);
      check(host_drv_dis_n == e_drv, "R8 drv", host_drv_dis_n, e_drv);
      check(host_rdata == e_dout[7:0], "R2 host_rdata", host_rdata, e_dout);
      check(mpu_rdata == e_mrd[7:0], "R11 mpu_rdata", mpu_rdata, e_mrd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic host_acc(input bit use_cs, input logic [2:0] a, input bit wr,
                          input logic [7:0] d, output logic [7:0] rv, output int n_irq);
    logic i0;
    i0 = host_irq; n_irq = 0; rv = '0;
    host_addr = a; host_wdata = d;
    host_cs_n = !use_cs;
    if (wr) host_wr_n = 0; else host_rd_n = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 2) rv = host_rdata;
      if (n_irq == 0 && host_irq != i0) n_irq = k;
      if (k == 4) begin host_cs_n = 1; host_rd_n = 1; host_wr_n = 1; end
    end
  endtask

  task automatic mpu_acc(input logic [1:0] a, input bit wr, input logic [7:0] d,
                         output logic [7:0] rv, output int n_irq);
    logic i0;
    i0 = host_irq; n_irq = 0; rv = '0;
    mpu_addr = a; mpu_wdata = d;
    if (wr) mpu_wr = 1; else mpu_rd = 1;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 1) begin mpu_wr = 0; mpu_rd = 0; rv = mpu_rdata; end
      if (n_irq == 0 && host_irq != i0) n_irq = k;
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 50000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_up();
    end
  end

  initial begin
    logic [7:0] rv;
    int n;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(host_irq == 0, "R1 irq", host_irq, 0);
    check(host_drv_dis_n == 1, "R1 drv", host_drv_dis_n, 1);
    host_acc(1, 3'd5, 0, 8'h00, rv, n); check(rv == 8'h60, "R1 lsr", rv, 8'h60);
    host_acc(1, 3'd2, 0, 8'h00, rv, n); check(rv == 8'h01, "R1 iid", rv, 8'h01);
    host_acc(1, 3'd1, 0, 8'h00, rv, n); check(rv == 8'h00, "R1 ier", rv, 8'h00);
    // R2 no chip select, unmapped addresses
    host_acc(0, 3'd1, 1, 8'h07, rv, n);
    host_acc(1, 3'd1, 0, 8'h00, rv, n); check(rv == 8'h00, "R2 ier no cs", rv, 8'h00);
    check(n == 0, "R2 irq no cs", n, 0);
    host_acc(1, 3'd3, 1, 8'hFF, rv, n);
    host_acc(1, 3'd3, 0, 8'h00, rv, n); check(rv == 8'h00, "R2 addr3", rv, 8'h00);
    host_acc(1, 3'd6, 0, 8'h00, rv, n); check(rv == 8'h00, "R2 addr6", rv, 8'h00);
    // R3 enable all: transmit-empty pending, irq after 5 edges
    host_acc(1, 3'd1, 1, 8'hFF, rv, n); check(n == 5, "R3 ier->irq edges", n, 5);
    host_acc(1, 3'd1, 0, 8'h00, rv, n); check(rv == 8'h07, "R10 ier mask", rv, 8'h07);
    host_acc(1, 3'd2, 0, 8'h00, rv, n); check(rv == 8'h02, "R10 iid tx", rv, 8'h02);
    // R6 host THR write clears transmit interrupt 3 clocks after commit
    host_acc(1, 3'd0, 1, 8'hA5, rv, n); check(n == 6, "R6 thr clear edges", n, 6);
    host_acc(1, 3'd5, 0, 8'h00, rv, n); check(rv == 8'h00, "R6 lsr", rv, 8'h00);
    // R7 MPU takes byte
    mpu_acc(2'd0, 0, 8'h00, rv, n);
    check(rv == 8'hA5, "R7 thr data", rv, 8'hA5);
    check(n == 3, "R7 irq edges", n, 3);
    // enable only rx and line status
    host_acc(1, 3'd1, 1, 8'h05, rv, n); check(n == 5, "R10 ier off edges", n, 5);
    mpu_acc(2'd2, 0, 8'h00, rv, n); check(rv == 8'h05, "R11 mpu ier", rv, 8'h05);
    // R4 MPU puts byte
    mpu_acc(2'd0, 1, 8'h3C, rv, n); check(n == 3, "R4 irq edges", n, 3);
    host_acc(1, 3'd2, 0, 8'h00, rv, n); check(rv == 8'h04, "R10 iid rx", rv, 8'h04);
    host_acc(1, 3'd5, 0, 8'h00, rv, n); check(rv == 8'h61, "R4 lsr dr", rv, 8'h61);
    // R5 host reads byte
    host_acc(1, 3'd0, 0, 8'h00, rv, n);
    check(rv == 8'h3C, "R5 rbr data", rv, 8'h3C);
    check(n == 5, "R5 irq clear edges", n, 5);
    // R9 overrun
    mpu_acc(2'd0, 1, 8'h11, rv, n);
    mpu_acc(2'd0, 1, 8'h22, rv, n);
    mpu_acc(2'd1, 0, 8'h00, rv, n); check(rv == 8'h63, "R9 mpu lsr oe", rv, 8'h63);
    host_acc(1, 3'd2, 0, 8'h00, rv, n); check(rv == 8'h06, "R10 iid ls first", rv, 8'h06);
    host_acc(1, 3'd5, 0, 8'h00, rv, n); check(rv == 8'h63, "R9 host lsr", rv, 8'h63);
    host_acc(1, 3'd2, 0, 8'h00, rv, n); check(rv == 8'h04, "R9 oe cleared", rv, 8'h04);
    host_acc(1, 3'd0, 0, 8'h00, rv, n); check(rv == 8'h22, "R9 last byte", rv, 8'h22);
    host_acc(1, 3'd2, 0, 8'h00, rv, n); check(rv == 8'h01, "R10 iid none", rv, 8'h01);
    check(host_irq == 0, "R5 irq idle", host_irq, 0);
    mpu_acc(2'd3, 0, 8'h00, rv, n); check(rv == 8'h00, "R11 mpu addr3", rv, 8'h00);
    repeat (4) @(negedge clk);
    done = 1;
    finish_up();
  end
endmodule